// File: doc/BRIEF.md
# Branch and Jump Next-PC Selector

This combinational unit picks the program counter for the next instruction fetch. It also produces the return-address write for the linking forms of branches and jumps. The decode stage supplies the current PC, a 4-bit control-flow code and two register operands, `rs` and `rt`. It also supplies the 16-bit branch displacement and the 26-bit jump target field. The unit returns the next PC, a write enable for the return-address register (register 31) and the value to write there.

Six conditions are supported:
- equality and inequality of `rs` and `rt`;
- four signed tests of `rs` against zero.

Branch targets are relative to the sequential address PC+4. Direct jumps keep the top bits of PC+4 and replace the rest with the word-aligned target field. Register-indirect jumps take `rs` as the next PC as-is. A separate flag tells the fetch side when that register value is not word aligned.

Top module: `npc_branch_unit`

## Requirements
- R1: Codes 0 (sequential) and the unused codes 13, 14 and 15 give next PC = PC+4 and never raise the link enable.
- R2: Code 1 is taken when `rs` equals `rt`. Code 2 is taken when they differ.
- R3: Codes 3 and 7 are taken when `rs` as a signed number is below zero. Codes 6 and 8 are taken when it is zero or above.
- R4: Code 4 is taken when signed `rs` is above zero. Code 5 is taken when it is zero or below.
- R5: A taken branch gives PC+4 plus the sign-extended displacement shifted left by two. A branch that is not taken gives PC+4. All sums wrap at 32 bits.
- R6: Codes 9 and 10 (direct jump) give bits 31..28 of PC+4, followed by the 26-bit target, followed by two zero bits.
- R7: Codes 11 and 12 (register jump) give next PC = `rs` unchanged.
- R8: Codes 7, 8, 10 and 12 raise the link enable with link address = PC+4, whether or not the branch is taken. Every other code keeps the link enable low.
- R9: The misalignment flag is high exactly when the code is 11 or 12 and `rs` bits 1..0 are not both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| op_i | input | 4 | Control-flow code from decode |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand |
| disp_i | input | 16 | Branch displacement in words |
| jfield_i | input | 26 | Direct jump target field |
| next_pc_o | output | 32 | Address to fetch next |
| link_we_o | output | 1 | Return-address write enable |
| link_addr_o | output | 32 | Return address for register 31 |
| misalign_o | output | 1 | Register jump target not word aligned |

## Verification
Every one of the 16 codes is driven against these `rs` values:
- zero, one and minus one;
- the most negative and most positive numbers;
- a misaligned small value.

Each is paired with `rt` values both equal and unequal to `rs`. Zero and the two extreme values separate the strict tests from the inclusive ones and signed from unsigned compares. Equal and unequal pairs separate the code 1 and code 2 tests.

Each sweep is repeated with three PC and displacement sets:
- a PC just under a 256 MiB region boundary, which shows whether jump region bits come from PC+4 rather than PC;
- a negative displacement, which shows whether sign extension is done;
- a wrap-around case at the top of the address space.

// File: rtl/npc_pkg.sv
// Shared types for the next-PC selector.
// Assumes the 4-bit control-flow code comes from the decode stage.
package npc_pkg;

    typedef enum logic [3:0] {
        NPC_SEQ      = 4'd0,
        NPC_BR_EQ    = 4'd1,
        NPC_BR_NE    = 4'd2,
        NPC_BR_LTZ   = 4'd3,
        NPC_BR_GTZ   = 4'd4,
        NPC_BR_LEZ   = 4'd5,
        NPC_BR_GEZ   = 4'd6,
        NPC_BR_LTZ_L = 4'd7,
        NPC_BR_GEZ_L = 4'd8,
        NPC_J_DIR    = 4'd9,
        NPC_J_DIR_L  = 4'd10,
        NPC_J_REG    = 4'd11,
        NPC_J_REG_L  = 4'd12
    } npc_op_e;

    // Coarse class of a code; it steers the next-PC multiplexer.
    typedef enum logic [1:0] {
        CLS_SEQ  = 2'd0,
        CLS_BR   = 2'd1,
        CLS_JDIR = 2'd2,
        CLS_JREG = 2'd3
    } npc_class_e;

endpackage

// File: rtl/npc_cond_eval.sv
// Branch condition evaluator.
// Decides whether a conditional code is taken.
// Zero compares treat rs as two's complement.
// Output is don't-care for codes that are not conditional.
module npc_cond_eval
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  npc_op_e          op_i,
    input  logic [XLEN-1:0]  rs_i,
    input  logic [XLEN-1:0]  rt_i,
    output logic             taken_o
);

    logic same;
    logic neg;
    logic zero;

    // Derive the three primitive relations once.
    always_comb begin
        same = (rs_i == rt_i);
        neg  = rs_i[XLEN-1];
        zero = (rs_i == '0);
    end

    // Map the code onto one of the primitive relations.
    always_comb begin
        unique case (op_i)
            NPC_BR_EQ:                  taken_o = same;
            NPC_BR_NE:                  taken_o = !same;
            NPC_BR_LTZ, NPC_BR_LTZ_L:   taken_o = neg;
            NPC_BR_GEZ, NPC_BR_GEZ_L:   taken_o = !neg;
            NPC_BR_GTZ:                 taken_o = !neg && !zero;
            NPC_BR_LEZ:                 taken_o = neg || zero;
            default:                    taken_o = 1'b0;
        endcase
    end

    // Guard: the signed-below-zero test must follow the sign bit.
    always_comb begin
        if (op_i == NPC_BR_LTZ && taken_o) begin
            AST_LTZ_SIGN: assert (rs_i[XLEN-1]) else $error("ltz taken on non-negative"); // R3
        end
        if (op_i == NPC_BR_GTZ && taken_o) begin
            AST_GTZ_NONZERO: assert (rs_i != '0) else $error("gtz taken on zero"); // R4
        end
    end

endmodule

// File: rtl/npc_target_gen.sv
// Target address generator.
// Forms the sequential address, the PC-relative branch target and the region-relative direct jump target.
// Assumes 4-byte instructions, so word offsets shift left by two.
module npc_target_gen #(
    parameter int XLEN   = 32,
    parameter int DISP_W = 16,
    parameter int JF_W   = 26
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [JF_W-1:0]   jfield_i,
    output logic [XLEN-1:0]   seq_o,
    output logic [XLEN-1:0]   br_tgt_o,
    output logic [XLEN-1:0]   jdir_tgt_o
);

    localparam int REGION_W = XLEN - JF_W - 2;
    localparam int EXT_W    = XLEN - DISP_W - 2;

    logic [XLEN-1:0] offset;

    // Sequential address and sign-extended byte offset.
    always_comb begin
        seq_o  = pc_i + XLEN'(4);
        offset = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, 2'b00};
    end

    // Branch and direct jump targets, both anchored on PC+4.
    always_comb begin
        br_tgt_o   = seq_o + offset;
        jdir_tgt_o = {seq_o[XLEN-1 -: REGION_W], jfield_i, 2'b00};
    end

    // Guard: a direct jump target is always word aligned.
    always_comb begin
        AST_JDIR_ALIGNED: assert (jdir_tgt_o[1:0] == 2'b00) else $error("jump target misaligned"); // R6
    end

endmodule

// File: rtl/npc_branch_unit.sv
// Next-PC selector (top).
// Classifies the control-flow code, picks the next PC, and drives the return-address write and the register-jump misalignment flag.
// Purely combinational; the PC register lives outside.
module npc_branch_unit
    import npc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int DISP_W = 16,
    parameter int JF_W   = 26
) (
    input  logic [XLEN-1:0]   pc_i,
    input  logic [3:0]        op_i,
    input  logic [XLEN-1:0]   rs_i,
    input  logic [XLEN-1:0]   rt_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [JF_W-1:0]   jfield_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              link_we_o,
    output logic [XLEN-1:0]   link_addr_o,
    output logic              misalign_o
);

    npc_op_e         op;
    npc_class_e      cls;
    logic            links;
    logic            taken;
    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jdir_tgt;

    assign op = npc_op_e'(op_i);

    npc_cond_eval #(.XLEN(XLEN)) u_cond (
        .op_i    (op),
        .rs_i    (rs_i),
        .rt_i    (rt_i),
        .taken_o (taken)
    );

    npc_target_gen #(.XLEN(XLEN), .DISP_W(DISP_W), .JF_W(JF_W)) u_tgt (
        .pc_i       (pc_i),
        .disp_i     (disp_i),
        .jfield_i   (jfield_i),
        .seq_o      (seq_addr),
        .br_tgt_o   (br_tgt),
        .jdir_tgt_o (jdir_tgt)
    );

    // Classify the code and note whether it links.
    always_comb begin
        cls   = CLS_SEQ;
        links = 1'b0;
        unique case (op)
            NPC_BR_EQ, NPC_BR_NE, NPC_BR_LTZ, NPC_BR_GTZ,
            NPC_BR_LEZ, NPC_BR_GEZ:       cls = CLS_BR;
            NPC_BR_LTZ_L, NPC_BR_GEZ_L: begin
                cls   = CLS_BR;
                links = 1'b1;
            end
            NPC_J_DIR:                    cls = CLS_JDIR;
            NPC_J_DIR_L: begin
                cls   = CLS_JDIR;
                links = 1'b1;
            end
            NPC_J_REG:                    cls = CLS_JREG;
            NPC_J_REG_L: begin
                cls   = CLS_JREG;
                links = 1'b1;
            end
            default: begin
                cls   = CLS_SEQ;
                links = 1'b0;
            end
        endcase
    end

    // Select the next PC from the class and the branch decision.
    always_comb begin
        unique case (cls)
            CLS_BR:   next_pc_o = taken ? br_tgt : seq_addr;
            CLS_JDIR: next_pc_o = jdir_tgt;
            CLS_JREG: next_pc_o = rs_i;
            default:  next_pc_o = seq_addr;
        endcase
    end

    // Return-address write and register-target alignment flag.
    always_comb begin
        link_we_o   = links;
        link_addr_o = seq_addr;
        misalign_o  = (cls == CLS_JREG) && (rs_i[1:0] != 2'b00);
    end

    // Guards relating the selector outputs to its inputs.
    always_comb begin
        if (op_i == 4'd0 || op_i > 4'd12) begin
            AST_SEQ_FALLTHRU: assert (next_pc_o == pc_i + XLEN'(4) && !link_we_o) else $error("sequential path broken"); // R1
        end
        if (cls == CLS_BR && !taken) begin
            AST_NOT_TAKEN_SEQ: assert (next_pc_o == pc_i + XLEN'(4)) else $error("untaken branch redirected"); // R5
        end
        if (cls == CLS_JREG) begin
            AST_REG_TARGET: assert (next_pc_o == rs_i) else $error("register jump target"); // R7
        end
        if (link_we_o) begin
            AST_LINK_ADDR: assert (link_addr_o == pc_i + XLEN'(4)) else $error("link address"); // R8
        end
        if (misalign_o) begin
            AST_MISALIGN_SCOPE: assert (op_i == 4'd11 || op_i == 4'd12) else $error("misalign on wrong code"); // R9
        end
    end

endmodule

// File: tb/npc_branch_unit_test.sv
// Sweep bench for the next-PC selector.
// Expected values are computed arithmetically from the requirements.
module npc_branch_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic [31:0] pc;
    logic [3:0]  op;
    logic [31:0] rs;
    logic [31:0] rt;
    logic [15:0] disp;
    logic [25:0] jfield;
    logic [31:0] next_pc;
    logic        link_we;
    logic [31:0] link_addr;
    logic        misalign;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    npc_branch_unit uut (
        .pc_i        (pc),
        .op_i        (op),
        .rs_i        (rs),
        .rt_i        (rt),
        .disp_i      (disp),
        .jfield_i    (jfield),
        .next_pc_o   (next_pc),
        .link_we_o   (link_we),
        .link_addr_o (link_addr),
        .misalign_o  (misalign)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s op=%0d pc=%h rs=%h rt=%h disp=%h actual=%h expected=%h",
                     req, op, pc, rs, rt, disp, got, exp);
        end
    endtask

    // Which requirement governs the next PC for a code.
    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd1, 4'd2:                return "R2";
            4'd3, 4'd6, 4'd7, 4'd8:    return "R3";
            4'd4, 4'd5:                return "R4";
            4'd9, 4'd10:               return "R6";
            4'd11, 4'd12:              return "R7";
            default:                   return "R1";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rs_set [6];
        logic [31:0] pc_set [3];
        logic [15:0] dp_set [3];
        logic [25:0] jf_set [3];
        rs_set = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0106};
        pc_set = '{32'h0FFF_FFFC, 32'h0040_0100, 32'hFFFF_FFF8};
        dp_set = '{16'h0003, 16'hFFFE, 16'h8000};
        jf_set = '{26'h3FF_FFFF, 26'h012_3456, 26'h000_0001};

        // Idle inputs: sequential code at address zero.
        pc = '0; op = '0; rs = '0; rt = '0; disp = '0; jfield = '0;
        @(negedge clk);
        check("R1", next_pc, 32'h4);
        check("R1", {31'b0, link_we}, 32'h0);
        check("R9", {31'b0, misalign}, 32'h0);

        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 16; c++) begin
                for (int a = 0; a < 6; a++) begin
                    for (int b = 0; b < 3; b++) begin
                        logic [31:0] seq, btgt, jtgt, exp_pc;
                        logic        tk, lk, mis;
                        logic signed [31:0] s;
                        pc     = pc_set[p];
                        disp   = dp_set[p];
                        jfield = jf_set[p];
                        op     = 4'(c);
                        rs     = rs_set[a];
                        rt     = (b == 0) ? rs_set[a] : (b == 1) ? ~rs_set[a] : rs_set[a] + 32'd4;
                        @(negedge clk);

                        s    = $signed(rs);
                        seq  = pc + 32'd4;
                        btgt = seq + ($signed({{16{disp[15]}}, disp}) * 4);
                        jtgt = {seq[31:28], jfield, 2'b00};
                        case (c)
                            1:       tk = (rs == rt);
                            2:       tk = (rs != rt);
                            3, 7:    tk = (s < 0);
                            4:       tk = (s > 0);
                            5:       tk = (s <= 0);
                            6, 8:    tk = (s >= 0);
                            default: tk = 1'b0;
                        endcase
                        if (c >= 1 && c <= 8)        exp_pc = tk ? btgt : seq;  // R5
                        else if (c == 9 || c == 10)  exp_pc = jtgt;
                        else if (c == 11 || c == 12) exp_pc = rs;
                        else                         exp_pc = seq;
                        lk  = (c == 7 || c == 8 || c == 10 || c == 12);
                        mis = (c == 11 || c == 12) && (rs[1:0] != 2'b00);

                        if (c >= 1 && c <= 8) check("R5", next_pc, exp_pc);
                        else                  check(req_of(4'(c)), next_pc, exp_pc);
                        check("R8", {31'b0, link_we}, {31'b0, lk});
                        if (lk) check("R8", link_addr, seq);
                        check("R9", {31'b0, misalign}, {31'b0, mis});
                    end
                end
            end
        end

        // Region boundary: the jump keeps region bits of PC+4, not of PC.
        pc = 32'h0FFF_FFFC; op = 4'd9; jfield = 26'h000_0010; rs = '0; rt = '0; disp = '0;
        @(negedge clk);
        check("R6", next_pc, 32'h1000_0040);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule